// File: doc/BRIEF.md
# Debug Trigger Chain Resolver

This block sits between the address and data comparators of ten hardware debug triggers and the trap logic of a processor pipeline. Each cycle it receives one raw match bit per trigger. It qualifies each bit with that trigger's stored enable. It then applies pairwise chaining and timing rules and produces a registered fire vector. It also produces two registered summary flags. The first asks for a trap before the current instruction retires. The second asks for a trap once it has retired.

The ten triggers form five fixed pairs: trigger 2p and trigger 2p+1 make up pair p. The pairs watch these event kinds: pair 0 (fetch, fetch), pair 1 (store, store), pair 2 (load, load), pair 3 (fetch, store) and pair 4 (fetch, load). Chaining turns a pair into a single two-condition trigger. The store/store pair can never be chained. The per-trigger control fields are loaded through a write port that carries a side bit and a small index. The block keeps the control fields that the comparators need and drives them back out on the `cfg_*` outputs.

The block is pure datapath with a register stage and has no sequencing states. Each cycle stands alone: whatever is sampled at one rising edge shows on the outputs after that edge.

Top module: `trig_chain_top`

## Requirements
- R1: With its pair unchained, an enabled trigger t asserts trig_fire[t] in the cycle after trig_hit[t] was sampled high, and trig_fire[t] is low in the cycle after trig_hit[t] was sampled low.
- R2: A trigger whose enable field is 0 never fires. When its pair is chained, its partner does not fire either.
- R3: In a chained pair, both members fire together when both are enabled and both hit in the same cycle. Otherwise neither member fires.
- R4: In a chained pair whose two timing fields differ, neither member fires, even when both hit.
- R5: The chain field of pair 1 (triggers 2 and 3) is treated as 0 whatever value was written, so each of those triggers fires on its own hit.
- R6: trap_now is high exactly when some fired trigger has timing field 0 (trap at the current instruction). trap_after is high exactly when some fired trigger has timing field 1 (trap at the next instruction). Both appear in the same cycle as trig_fire.
- R7: A write with cw_mem=0 addresses a fetch trigger: cw_idx[1:0] values 0,1,2,3 select triggers 0,1,6,8, and cw_idx[2] is ignored. A write with cw_mem=1 addresses a memory trigger: cw_idx values 0..5 select triggers 2,3,4,5,7,9. Memory-side cw_idx values 6 and 7 change nothing.
- R8: A pair's chain field is taken only from writes to its even-numbered member. A chain value written to an odd-numbered member has no effect.
- R9: Reset clears every enable, timing, chain and stored field, so trig_fire, trap_now, trap_after and all cfg outputs are 0 after reset.
- R10: In the cycle after a write, the slices of cfg_mtype, cfg_select, cfg_action and cfg_cmp for the addressed trigger hold the written values. Trigger t uses bits [2t+1:2t] of cfg_mtype, bit t of cfg_select and cfg_action, and bits [64t+63:64t] of cfg_cmp.
- R11: A hit sampled in the same cycle as a write is resolved with the configuration that was in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_hit | input | 10 | Raw comparator match, one bit per trigger |
| cw_valid | input | 1 | Control write strobe |
| cw_mem | input | 1 | Write side: 0 fetch triggers, 1 memory triggers |
| cw_idx | input | 3 | Trigger index within the selected side |
| cw_mtype | input | 2 | Match type field |
| cw_select | input | 1 | Compare-select field |
| cw_timing | input | 1 | 0 trap now, 1 trap after |
| cw_action | input | 1 | Action field |
| cw_chain | input | 1 | Chain field (used for even members only) |
| cw_enable | input | 1 | Trigger enable |
| cw_cmp | input | 64 | Compare value |
| trig_fire | output | 10 | Registered per-trigger fire vector |
| trap_now | output | 1 | Some fired trigger asks for a trap at the current instruction |
| trap_after | output | 1 | Some fired trigger asks for a trap at the next instruction |
| cfg_mtype | output | 20 | Stored match types, 2 bits per trigger |
| cfg_select | output | 10 | Stored select bits |
| cfg_action | output | 10 | Stored action bits |
| cfg_cmp | output | 640 | Stored compare values, 64 bits per trigger |

## Verification
The properties relate each fire bit to the hit, enable, timing and chain values of the previous cycle. They therefore assume that trig_hit and every write-port input hold known values at each rising edge after reset. They make no assumption that writes and hits are kept apart in time. The stimulus drives every input to a defined value from time zero and changes inputs only on falling edges. It deliberately places a write and a hit in the same cycle to reach the case where the old configuration still applies.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int NPAIR      = 5;
    localparam int NTRIG      = 2 * NPAIR;
    localparam int FIDX_W     = 2;
    localparam int MIDX_W     = 3;
    localparam int STORE_PAIR = 1;

    typedef enum logic [1:0] {
        EV_FETCH = 2'd0,
        EV_LOAD  = 2'd1,
        EV_STORE = 2'd2
    } ev_kind_e;

    typedef struct packed {
        logic [1:0] mtype;
        logic       sel;
        logic       timing;
        logic       action;
        logic       enable;
    } trig_ctl_t;

    // Event kind watched by each trigger; pairs are fixed in hardware.
    function automatic ev_kind_e member_kind(input int t);
        case (t)
            0, 1, 6, 8: return EV_FETCH;
            2, 3, 7:    return EV_STORE;
            default:    return EV_LOAD;
        endcase
    endfunction

    function automatic bit is_fetch(input int t);
        return member_kind(t) == EV_FETCH;
    endfunction

    // Position of trigger t among the triggers on its own write side.
    function automatic int side_rank(input int t);
        int r;
        r = 0;
        for (int s = 0; s < t; s++) begin
            if (is_fetch(s) == is_fetch(t)) r++;
        end
        return r;
    endfunction

endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
    import trig_pkg::*;
#(
    parameter int CMP_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cw_valid,
    input  logic                    cw_mem,
    input  logic [MIDX_W-1:0]       cw_idx,
    input  logic [1:0]              cw_mtype,
    input  logic                    cw_select,
    input  logic                    cw_timing,
    input  logic                    cw_action,
    input  logic                    cw_chain,
    input  logic                    cw_enable,
    input  logic [CMP_W-1:0]        cw_cmp,
    output logic [NTRIG-1:0]        en_o,
    output logic [NTRIG-1:0]        tim_o,
    output logic [NPAIR-1:0]        chain_raw_o,
    output logic [2*NTRIG-1:0]      mtype_o,
    output logic [NTRIG-1:0]        sel_o,
    output logic [NTRIG-1:0]        act_o,
    output logic [NTRIG*CMP_W-1:0]  cmp_o
);

    logic [NTRIG-1:0] wsel;

    for (genvar t = 0; t < NTRIG; t++) begin : g_trig
        localparam bit IS_F = is_fetch(t);
        localparam int RK   = side_rank(t);

        trig_ctl_t        ctl_q;
        logic [CMP_W-1:0] cmp_q;

        if (IS_F) begin : g_fetch
            assign wsel[t] = cw_valid && !cw_mem
                             && (cw_idx[FIDX_W-1:0] == FIDX_W'(RK));
        end else begin : g_mem
            assign wsel[t] = cw_valid && cw_mem
                             && (cw_idx == MIDX_W'(RK));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q <= '0;
                cmp_q <= '0;
            end else if (wsel[t]) begin
                ctl_q.mtype  <= cw_mtype;
                ctl_q.sel    <= cw_select;
                ctl_q.timing <= cw_timing;
                ctl_q.action <= cw_action;
                ctl_q.enable <= cw_enable;
                cmp_q        <= cw_cmp;
            end
        end

        assign en_o[t]                 = ctl_q.enable;
        assign tim_o[t]                = ctl_q.timing;
        assign mtype_o[2*t +: 2]       = ctl_q.mtype;
        assign sel_o[t]                = ctl_q.sel;
        assign act_o[t]                = ctl_q.action;
        assign cmp_o[CMP_W*t +: CMP_W] = cmp_q;
    end

    // Pair chain field is owned by the even member only.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          chain_q <= 1'b0;
            else if (wsel[2*p])  chain_q <= cw_chain;
        end
        assign chain_raw_o[p] = chain_q;
    end

endmodule

// File: rtl/trig_pair_resolve.sv
module trig_pair_resolve (
    input  logic [1:0] hit,
    input  logic [1:0] en,
    input  logic [1:0] tim,
    input  logic       chain,
    output logic [1:0] fire
);

    logic [1:0] qual;
    logic       both;

    always_comb begin
        qual = hit & en;
        both = (&qual) && (tim[0] == tim[1]);
        if (chain) fire = {2{both}};
        else       fire = qual;
    end

endmodule

// File: rtl/trig_chain_top.sv
module trig_chain_top
    import trig_pkg::*;
#(
    parameter int CMP_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NTRIG-1:0]        trig_hit,
    input  logic                    cw_valid,
    input  logic                    cw_mem,
    input  logic [MIDX_W-1:0]       cw_idx,
    input  logic [1:0]              cw_mtype,
    input  logic                    cw_select,
    input  logic                    cw_timing,
    input  logic                    cw_action,
    input  logic                    cw_chain,
    input  logic                    cw_enable,
    input  logic [CMP_W-1:0]        cw_cmp,
    output logic [NTRIG-1:0]        trig_fire,
    output logic                    trap_now,
    output logic                    trap_after,
    output logic [2*NTRIG-1:0]      cfg_mtype,
    output logic [NTRIG-1:0]        cfg_select,
    output logic [NTRIG-1:0]        cfg_action,
    output logic [NTRIG*CMP_W-1:0]  cfg_cmp
);

    logic [NTRIG-1:0] en_q;
    logic [NTRIG-1:0] tim_q;
    logic [NPAIR-1:0] chain_raw;
    logic [NPAIR-1:0] pair_chain;
    logic [NTRIG-1:0] fire_d;
    logic             now_d;
    logic             after_d;

    trig_cfg_bank #(.CMP_W(CMP_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cw_valid   (cw_valid),
        .cw_mem     (cw_mem),
        .cw_idx     (cw_idx),
        .cw_mtype   (cw_mtype),
        .cw_select  (cw_select),
        .cw_timing  (cw_timing),
        .cw_action  (cw_action),
        .cw_chain   (cw_chain),
        .cw_enable  (cw_enable),
        .cw_cmp     (cw_cmp),
        .en_o       (en_q),
        .tim_o      (tim_q),
        .chain_raw_o(chain_raw),
        .mtype_o    (cfg_mtype),
        .sel_o      (cfg_select),
        .act_o      (cfg_action),
        .cmp_o      (cfg_cmp)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        if (p == STORE_PAIR) begin : g_nochain
            assign pair_chain[p] = 1'b0;
        end else begin : g_chain
            assign pair_chain[p] = chain_raw[p];
        end

        trig_pair_resolve u_res (
            .hit  (trig_hit[2*p +: 2]),
            .en   (en_q[2*p +: 2]),
            .tim  (tim_q[2*p +: 2]),
            .chain(pair_chain[p]),
            .fire (fire_d[2*p +: 2])
        );
    end

    always_comb begin
        now_d   = |(fire_d & ~tim_q);
        after_d = |(fire_d & tim_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_fire  <= '0;
            trap_now   <= 1'b0;
            trap_after <= 1'b0;
        end else begin
            trig_fire  <= fire_d;
            trap_now   <= now_d;
            trap_after <= after_d;
        end
    end

endmodule

// File: rtl/trig_chain_chk.sv
module trig_chain_chk
    import trig_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NTRIG-1:0] trig_hit,
    input logic [NTRIG-1:0] trig_fire,
    input logic             trap_now,
    input logic             trap_after,
    input logic [NTRIG-1:0] en_q,
    input logic [NTRIG-1:0] tim_q,
    input logic [NPAIR-1:0] pair_chain
);

    p_fire_needs_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_fire & ~$past(trig_hit)) == '0);

    p_fire_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_fire & ~$past(en_q)) == '0);

    p_trap_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_now == |(trig_fire & ~$past(tim_q)));

    p_trap_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_after == |(trig_fire & $past(tim_q)));

    p_store_pair_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trig_hit[2*STORE_PAIR] && en_q[2*STORE_PAIR]) |-> trig_fire[2*STORE_PAIR]);

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (trig_fire == '0) && !trap_now && !trap_after);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        p_chain_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pair_chain[p]) |-> (trig_fire[2*p] == trig_fire[2*p+1]));

        p_timing_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pair_chain[p] && (tim_q[2*p] != tim_q[2*p+1]))
            |-> !trig_fire[2*p] && !trig_fire[2*p+1]);
    end

endmodule

bind trig_chain_top trig_chain_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_hit  (trig_hit),
    .trig_fire (trig_fire),
    .trap_now  (trap_now),
    .trap_after(trap_after),
    .en_q      (en_q),
    .tim_q     (tim_q),
    .pair_chain(pair_chain)
);

// File: tb/test_trig_chain_top.sv
module test_trig_chain_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 10;
    localparam int CW = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NT-1:0]     trig_hit = '0;
    logic              cw_valid = 1'b0;
    logic              cw_mem = 1'b0;
    logic [2:0]        cw_idx = '0;
    logic [1:0]        cw_mtype = '0;
    logic              cw_select = 1'b0;
    logic              cw_timing = 1'b0;
    logic              cw_action = 1'b0;
    logic              cw_chain = 1'b0;
    logic              cw_enable = 1'b0;
    logic [CW-1:0]     cw_cmp = '0;
    logic [NT-1:0]     trig_fire;
    logic              trap_now;
    logic              trap_after;
    logic [2*NT-1:0]   cfg_mtype;
    logic [NT-1:0]     cfg_select;
    logic [NT-1:0]     cfg_action;
    logic [NT*CW-1:0]  cfg_cmp;

    int n_vec = 0;
    int n_bad = 0;

    logic [NT-1:0] m_en  = '0;
    logic [NT-1:0] m_tim = '0;
    logic [4:0]    m_ch  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_chain_top i_trig_chain_top (
        .clk(clk), .rst_n(rst_n), .trig_hit(trig_hit),
        .cw_valid(cw_valid), .cw_mem(cw_mem), .cw_idx(cw_idx),
        .cw_mtype(cw_mtype), .cw_select(cw_select), .cw_timing(cw_timing),
        .cw_action(cw_action), .cw_chain(cw_chain), .cw_enable(cw_enable),
        .cw_cmp(cw_cmp), .trig_fire(trig_fire), .trap_now(trap_now),
        .trap_after(trap_after), .cfg_mtype(cfg_mtype), .cfg_select(cfg_select),
        .cfg_action(cfg_action), .cfg_cmp(cfg_cmp)
    );

    task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Trigger selected by a write, or -1 when the write selects none (R7).
    function automatic int map_id(input logic mem, input logic [2:0] idx);
        if (!mem) begin
            case (idx[1:0])
                2'd0: return 0;
                2'd1: return 1;
                2'd2: return 6;
                default: return 8;
            endcase
        end
        case (idx)
            3'd0: return 2;
            3'd1: return 3;
            3'd2: return 4;
            3'd3: return 5;
            3'd4: return 7;
            3'd5: return 9;
            default: return -1;
        endcase
    endfunction

    function automatic logic [NT-1:0] model_fire(input logic [NT-1:0] h);
        logic [NT-1:0] f;
        f = '0;
        for (int p = 0; p < 5; p++) begin
            logic qa, qb;
            qa = h[2*p] & m_en[2*p];
            qb = h[2*p+1] & m_en[2*p+1];
            if (m_ch[p] && p != 1) begin
                f[2*p]   = qa && qb && (m_tim[2*p] == m_tim[2*p+1]);
                f[2*p+1] = f[2*p];
            end else begin
                f[2*p]   = qa;
                f[2*p+1] = qb;
            end
        end
        return f;
    endfunction

    task automatic drive_wr(input logic mem, input logic [2:0] idx, input logic tim,
                            input logic ch, input logic en, input logic [CW-1:0] cmp);
        cw_valid = 1'b1; cw_mem = mem; cw_idx = idx; cw_timing = tim;
        cw_chain = ch; cw_enable = en; cw_cmp = cmp;
        cw_mtype = cmp[1:0]; cw_select = cmp[2]; cw_action = cmp[3];
    endtask

    task automatic model_wr(input logic mem, input logic [2:0] idx, input logic tim,
                            input logic ch, input logic en);
        int id;
        id = map_id(mem, idx);
        if (id >= 0) begin
            m_tim[id] = tim;
            m_en[id]  = en;
            if (id % 2 == 0) m_ch[id/2] = ch;
        end
    endtask

    task automatic wr(input logic mem, input logic [2:0] idx, input logic tim,
                      input logic ch, input logic en, input logic [CW-1:0] cmp);
        @(negedge clk);
        drive_wr(mem, idx, tim, ch, en, cmp);
        @(negedge clk);
        cw_valid = 1'b0;
        model_wr(mem, idx, tim, ch, en);
    endtask

    task automatic hit_chk(input string req, input logic [NT-1:0] h);
        logic [NT-1:0] ef;
        ef = model_fire(h);
        @(negedge clk);
        trig_hit = h;
        @(negedge clk);
        trig_hit = '0;
        chk({req, " fire"}, CW'(trig_fire), CW'(ef));
        chk({req, " trap_now"}, CW'(trap_now), CW'(|(ef & ~m_tim)));
        chk({req, " trap_after"}, CW'(trap_after), CW'(|(ef & m_tim)));
    endtask

    task automatic t_reset;
        chk("R9 reset fire", CW'(trig_fire), '0);
        chk("R9 reset traps", CW'({trap_now, trap_after}), '0);
        chk("R9 reset cmp", CW'(|cfg_cmp), '0);
        chk("R9 reset fields", CW'(|{cfg_mtype, cfg_select, cfg_action}), '0);
    endtask

    task automatic t_addr_map;
        logic [NT*CW-1:0] snap;
        for (int i = 0; i < 4; i++)
            wr(1'b0, 3'(i), map_id(1'b0, 3'(i)) % 3 == 0, 1'b0, 1'b1,
               CW'(64'h1000 + map_id(1'b0, 3'(i))));
        for (int i = 0; i < 6; i++)
            wr(1'b1, 3'(i), map_id(1'b1, 3'(i)) % 3 == 0, 1'b0, 1'b1,
               CW'(64'h1000 + map_id(1'b1, 3'(i))));
        for (int t = 0; t < NT; t++) begin
            logic [CW-1:0] v;
            v = CW'(64'h1000 + t);
            chk("R7 R10 cmp slice", cfg_cmp[CW*t +: CW], v);
            chk("R10 fields", CW'({cfg_action[t], cfg_select[t], cfg_mtype[2*t +: 2]}), CW'(v[3:0]));
        end
        snap = cfg_cmp;
        wr(1'b1, 3'd6, 1'b1, 1'b1, 1'b0, 64'hDEAD);
        wr(1'b1, 3'd7, 1'b1, 1'b1, 1'b0, 64'hBEEF);
        chk("R7 idx6/7 ignored cmp", CW'(cfg_cmp != snap), '0);
        hit_chk("R7 idx6/7 ignored fire", 10'h3FF);
        // fetch write with idx[2] set still selects trigger 6
        wr(1'b0, 3'd6, 1'b0, 1'b0, 1'b1, 64'h1006);
        chk("R7 fetch idx bit2 ignored", cfg_cmp[CW*6 +: CW], 64'h1006);
    endtask

    task automatic t_unchained;
        hit_chk("R1 R6 all", 10'h3FF);
        hit_chk("R1 R6 odd", 10'h155);
        hit_chk("R1 R6 even", 10'h2AA);
        hit_chk("R1 single", 10'h001);
        hit_chk("R1 none", 10'h000);
    endtask

    task automatic t_disable;
        wr(1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 64'h4);
        hit_chk("R2 chained disabled", 10'h030);
        hit_chk("R2 chained partner", 10'h020);
        wr(1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 64'h9);
        hit_chk("R2 unchained disabled", 10'h200);
        hit_chk("R2 neighbour unaffected", 10'h300);
    endtask

    task automatic t_chain;
        wr(1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 64'h0);
        wr(1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 64'h1);
        hit_chk("R3 one member", 10'h001);
        hit_chk("R3 other member", 10'h002);
        hit_chk("R3 both", 10'h003);
    endtask

    task automatic t_mismatch;
        wr(1'b0, 3'd1, 1'b1, 1'b0, 1'b1, 64'h1);
        hit_chk("R4 pair0 mismatch", 10'h003);
        wr(1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 64'h6);
        wr(1'b1, 3'd4, 1'b1, 1'b0, 1'b1, 64'h7);
        hit_chk("R4 pair3 mismatch", 10'h0C0);
        wr(1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 64'h7);
        hit_chk("R3 pair3 matched", 10'h0C0);
    endtask

    task automatic t_store_pair;
        wr(1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 64'h2);
        hit_chk("R5 store pair unchained", 10'h004);
        hit_chk("R5 store pair other", 10'h008);
    endtask

    task automatic t_odd_chain;
        wr(1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 64'h4);
        wr(1'b1, 3'd3, 1'b0, 1'b1, 1'b1, 64'h5);
        hit_chk("R8 odd chain ignored", 10'h010);
    endtask

    task automatic t_same_cycle;
        logic [NT-1:0] ef;
        ef = model_fire(10'h100);
        @(negedge clk);
        trig_hit = 10'h100;
        drive_wr(1'b0, 3'd3, ~m_tim[8], 1'b0, 1'b1, 64'h8);
        @(negedge clk);
        trig_hit = '0;
        cw_valid = 1'b0;
        chk("R11 fire old cfg", CW'(trig_fire), CW'(ef));
        chk("R11 trap_now old cfg", CW'(trap_now), CW'(|(ef & ~m_tim)));
        chk("R11 trap_after old cfg", CW'(trap_after), CW'(|(ef & m_tim)));
        model_wr(1'b0, 3'd3, ~m_tim[8], 1'b0, 1'b1);
        hit_chk("R6 R11 new timing", 10'h100);
    endtask

    task automatic t_rereset;
        @(negedge clk);
        rst_n = 1'b0;
        m_en = '0; m_tim = '0; m_ch = '0;
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        hit_chk("R9 no fire after reset", 10'h3FF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_addr_map();
        t_unchained();
        t_disable();
        t_chain();
        t_mismatch();
        t_store_pair();
        t_odd_chain();
        t_same_cycle();
        t_rereset();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule